// File: doc/BRIEF.md
# Sampling Multiplexer and Accumulation Sequencer

This block sets the timing of a six-channel polyphase sampling front end and groups multiplexer cycles into accumulation intervals. It advances only on a 32768 Hz tick enable, walking a position counter through a 13-tick multiplexer cycle: six 2-tick sample slots followed by one idle tick. Each slot selects one channel, in the order phase-A current, phase-A voltage, phase-B current, phase-B voltage, phase-C current, phase-C voltage. A sample strobe marks the last tick of each slot.

At the end of every multiplexer cycle the block raises a one-cycle cycle-end pulse. A second counter counts cycle ends and raises a one-cycle interval-end pulse when the programmed number of multiplexer cycles has passed. That number is the product of a prescale count, chosen by a 2-bit code, and a 6-bit sum count. Both come from one configuration byte. The configuration is captured on the first clock after reset release and again at each interval end, so changes made during an interval take effect only from the next one.

Top module: `mux_accum_seq`

## Requirements
- R1: The position counter advances by one on each clock with `tick_en_i` high and wraps after 13 ticks; one multiplexer cycle is exactly 13 ticks.
- R2: `chan_sel_o` is one-hot for ticks 0..11 of a cycle, selecting bit k for ticks 2k and 2k+1. Bit 0 is phase-A current, bit 1 phase-A voltage, bit 2 phase-B current, bit 3 phase-B voltage, bit 4 phase-C current and bit 5 phase-C voltage. On tick 12, the idle tick, it is all zero.
- R3: `sample_stb_o` is high only in a clock with `tick_en_i` high at tick 1, 3, 5, 7, 9 or 11 of the cycle, giving six strobes per multiplexer cycle.
- R4: `mux_done_o` is high exactly in the clock with `tick_en_i` high at tick 12, giving one pulse per multiplexer cycle.
- R5: `accum_done_o` pulses together with the `mux_done_o` of the last multiplexer cycle of an interval. An interval spans prescale count × sum count multiplexer cycles.
- R6: The prescale count is selected by `cfg_i[7:6]`: 00 selects 42, 01 selects 50, 10 selects 84 and 11 selects 100. The sum count is `cfg_i[5:0]`.
- R7: A sum count of zero is used as 1.
- R8: `cfg_i` is captured on the first clock after reset release and at each `accum_done_o`. A change at any other time does not alter the current interval.
- R9: With `tick_en_i` low, the position and interval counters hold, and `sample_stb_o`, `mux_done_o` and `accum_done_o` stay low.
- R10: After reset the position is tick 0: `chan_sel_o` = 000001 and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | 32768 Hz tick enable, one clock wide |
| cfg_i | input | 8 | Configuration: [7:6] prescale code, [5:0] sum count |
| chan_sel_o | output | 6 | One-hot channel select, all zero in the idle tick |
| sample_stb_o | output | 1 | Sample strobe on the last tick of a slot |
| mux_done_o | output | 1 | One-cycle pulse at the end of each multiplexer cycle |
| accum_done_o | output | 1 | One-cycle pulse at the end of each accumulation interval |

## Verification
Every output is decoded from registered state and `tick_en_i` in the same clock, so the strobe and both pulses are due in the cycle in which the tick is presented. The channel select moves one clock after a tick. The bench raises each tick at a falling edge, samples 1 ns later before the rising edge that advances state, and lowers the tick at the next falling edge. Interval lengths are measured as the tick count, counted from reset, at which `accum_done_o` appears, and compared against 13 × prescale × sum. Captured configuration is therefore seen exactly one clock after reset release or one clock after an interval pulse.

// File: rtl/mux_accum_pkg.sv
package mux_accum_pkg;
  localparam int unsigned PRESC_W   = 7;
  localparam int unsigned PRESC_MAX = 100;

  typedef enum logic [1:0] {
    PS_42  = 2'd0,
    PS_50  = 2'd1,
    PS_84  = 2'd2,
    PS_100 = 2'd3
  } presc_sel_e;

  function automatic logic [PRESC_W-1:0] presc_count(input presc_sel_e sel);
    case (sel)
      PS_42:   return 7'd42;
      PS_50:   return 7'd50;
      PS_84:   return 7'd84;
      default: return 7'd100;
    endcase
  endfunction
endpackage

// File: rtl/mux_slot_timer.sv
module mux_slot_timer #(
  parameter int unsigned CYC_TICKS = 13,
  parameter int unsigned POS_W     = $clog2(CYC_TICKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [POS_W-1:0] pos_o,
  output logic             wrap_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(CYC_TICKS - 1);

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (tick_i) begin
      pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  assign pos_o  = pos_q;
  assign wrap_o = tick_i && (pos_q == LAST);

  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= LAST);  // R1
  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pos_q));  // R9
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (pos_q == '0));  // R4
endmodule

// File: rtl/slot_decoder.sv
module slot_decoder #(
  parameter int unsigned NUM_CH     = 6,
  parameter int unsigned SLOT_TICKS = 2,
  parameter int unsigned POS_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              tick_i,
  output logic [NUM_CH-1:0] sel_o,
  output logic              stb_o
);
  logic [NUM_CH-1:0] slot_end;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_slot
    localparam logic [POS_W-1:0] LO = POS_W'(ch * SLOT_TICKS);
    localparam logic [POS_W-1:0] HI = POS_W'((ch + 1) * SLOT_TICKS - 1);
    assign sel_o[ch]    = (pos_i >= LO) && (pos_i <= HI);
    assign slot_end[ch] = (pos_i == HI);
  end

  assign stb_o = tick_i && (|slot_end);

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));  // R2
  AST_STB_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> (sel_o != '0));  // R3
endmodule

// File: rtl/accum_len_calc.sv
module accum_len_calc
  import mux_accum_pkg::*;
#(
  parameter int unsigned SUM_W = 6,
  parameter int unsigned LEN_W = 13
) (
  input  presc_sel_e       sel_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [LEN_W-1:0] len_o
);
  logic [SUM_W-1:0] sum_eff;

  // zero sum count behaves as one
  assign sum_eff = (sum_i == '0) ? SUM_W'(1) : sum_i;
  assign len_o   = LEN_W'(presc_count(sel_i)) * LEN_W'(sum_eff);
endmodule

// File: rtl/accum_counter.sv
module accum_counter
  import mux_accum_pkg::*;
#(
  parameter int unsigned SUM_W = 6,
  parameter int unsigned LEN_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_done_i,
  input  presc_sel_e       cfg_sel_i,
  input  logic [SUM_W-1:0] cfg_sum_i,
  output logic             acc_done_o
);
  logic [LEN_W-1:0] len_new;
  logic [LEN_W-1:0] target_q;
  logic [LEN_W-1:0] cnt_q;
  logic             armed_q;

  accum_len_calc #(.SUM_W(SUM_W), .LEN_W(LEN_W)) u_len (
    .sel_i (cfg_sel_i),
    .sum_i (cfg_sum_i),
    .len_o (len_new)
  );

  assign acc_done_o = cyc_done_i && (cnt_q == target_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_q <= LEN_W'(1);
      cnt_q    <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (!armed_q) begin
        target_q <= len_new;
        armed_q  <= 1'b1;
      end
      if (cyc_done_i) begin
        if (acc_done_o) begin
          cnt_q    <= '0;
          target_q <= len_new;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_CNT_BELOW_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < target_q);  // R5
  AST_LEN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !acc_done_o) |=> $stable(target_q));  // R8
  AST_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_q != '0);  // R7
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_done_i |=> $stable(cnt_q));  // R9
endmodule

// File: rtl/mux_accum_seq.sv
module mux_accum_seq
  import mux_accum_pkg::*;
#(
  parameter int unsigned NUM_CH     = 6,
  parameter int unsigned SLOT_TICKS = 2,
  parameter int unsigned IDLE_TICKS = 1,
  parameter int unsigned SUM_W      = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic [SUM_W+1:0]  cfg_i,
  output logic [NUM_CH-1:0] chan_sel_o,
  output logic              sample_stb_o,
  output logic              mux_done_o,
  output logic              accum_done_o
);
  localparam int unsigned CYC_TICKS = NUM_CH * SLOT_TICKS + IDLE_TICKS;
  localparam int unsigned POS_W     = $clog2(CYC_TICKS);
  localparam int unsigned LEN_W     = $clog2(PRESC_MAX * ((1 << SUM_W) - 1) + 1);

  logic [POS_W-1:0] pos;
  logic             cyc_wrap;
  presc_sel_e       cfg_sel;

  assign cfg_sel = presc_sel_e'(cfg_i[SUM_W+1:SUM_W]);

  mux_slot_timer #(.CYC_TICKS(CYC_TICKS), .POS_W(POS_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_en_i),
    .pos_o  (pos),
    .wrap_o (cyc_wrap)
  );

  slot_decoder #(.NUM_CH(NUM_CH), .SLOT_TICKS(SLOT_TICKS), .POS_W(POS_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pos_i  (pos),
    .tick_i (tick_en_i),
    .sel_o  (chan_sel_o),
    .stb_o  (sample_stb_o)
  );

  accum_counter #(.SUM_W(SUM_W), .LEN_W(LEN_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_done_i (cyc_wrap),
    .cfg_sel_i  (cfg_sel),
    .cfg_sum_i  (cfg_i[SUM_W-1:0]),
    .acc_done_o (accum_done_o)
  );

  assign mux_done_o = cyc_wrap;

  AST_ACC_ON_MUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accum_done_o |-> mux_done_o);  // R5
  AST_QUIET_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |-> (!sample_stb_o && !mux_done_o && !accum_done_o));  // R9
  AST_IDLE_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_done_o |-> (chan_sel_o == '0 && !sample_stb_o));  // R2
  AST_MUX_AFTER_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_done_o |-> !$past(sample_stb_o));  // R3
endmodule

// File: tb/mux_accum_seq_tb_top.sv
`timescale 1ns/1ps
module mux_accum_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic [7:0] cfg;
  logic [5:0] sel;
  logic       stb, mux_d, acc_d;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mux_accum_seq dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick_en_i    (tick_en),
    .cfg_i        (cfg),
    .chan_sel_o   (sel),
    .sample_stb_o (stb),
    .mux_done_o   (mux_d),
    .accum_done_o (acc_d)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic reset_dut(input logic [7:0] c);
    tick_en = 1'b0;
    cfg     = c;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one tick: raise at negedge, sample before the rising edge, lower next negedge
  task automatic do_tick();
    @(negedge clk);
    tick_en = 1'b1;
    #1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  logic [5:0] s_sel;
  logic       s_stb, s_mux, s_acc;

  task automatic tick_sample();
    @(negedge clk);
    tick_en = 1'b1;
    #1;
    s_sel = sel; s_stb = stb; s_mux = mux_d; s_acc = acc_d;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic run_to_acc(input int max_ticks, output int ticks, output int muxes);
    ticks = 0;
    muxes = 0;
    for (int i = 0; i < max_ticks; i++) begin
      tick_sample();
      ticks++;
      if (s_mux) muxes++;
      if (s_acc) break;
    end
  endtask

  task automatic t_reset();
    reset_dut(8'h01);
    #1;
    chk(sel == 6'b000001, "R10", "sel after reset", sel, 1);
    chk(!stb && !mux_d && !acc_d, "R10", "pulses after reset",
        {stb, mux_d, acc_d}, 0);
  endtask

  task automatic t_slot_walk();
    int n_stb, n_mux, bad_sel, bad_stb, bad_mux;
    reset_dut(8'h01);
    n_stb = 0; n_mux = 0; bad_sel = 0; bad_stb = 0; bad_mux = 0;
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 13; k++) begin
        logic [5:0] e_sel;
        e_sel = (k < 12) ? 6'(1 << (k / 2)) : 6'b0;
        tick_sample();
        if (s_sel != e_sel) begin
          bad_sel++;
          chk(1'b0, "R2", "chan_sel per tick", s_sel, e_sel);
        end
        if (s_stb != (k < 12 && k % 2 == 1)) bad_stb++;
        if (s_mux != (k == 12)) bad_mux++;
        n_stb += s_stb;
        n_mux += s_mux;
      end
    end
    chk(bad_sel == 0, "R2", "select mismatches", bad_sel, 0);
    chk(bad_stb == 0, "R3", "strobe mismatches", bad_stb, 0);
    chk(n_stb == 18, "R3", "strobes in 3 cycles", n_stb, 18);
    chk(bad_mux == 0, "R4", "cycle-end mismatches", bad_mux, 0);
    chk(n_mux == 3, "R1", "13-tick cycles in 39 ticks", n_mux, 3);
  endtask

  task automatic t_gap();
    logic [5:0] held;
    int pulses;
    reset_dut(8'h01);
    repeat (5) do_tick();
    #1 held = sel;
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      if (stb || mux_d || acc_d) pulses++;
      if (sel != held) pulses++;
    end
    chk(pulses == 0, "R9", "activity without tick", pulses, 0);
    chk(held == 6'b000100, "R9", "position held at tick 5", held, 6'b000100);
    tick_sample();
    chk(s_stb == 1'b1, "R9", "resume strobe at tick 5", s_stb, 1);
  endtask

  task automatic t_accum(input logic [7:0] c, input int exp_len, input int n_int,
                         input string req);
    int t, m;
    reset_dut(c);
    for (int j = 0; j < n_int; j++) begin
      run_to_acc(exp_len * 13 + 30, t, m);
      chk(t == exp_len * 13, req, "ticks per interval", t, exp_len * 13);
      chk(m == exp_len, req, "cycles per interval", m, exp_len);
    end
  endtask

  task automatic t_cfg_change();
    int t, m;
    reset_dut(8'h01);
    repeat (100) do_tick();
    cfg = 8'h41;
    run_to_acc(2000, t, m);
    chk(t == 42 * 13 - 100, "R8", "interval kept after mid change", t, 42 * 13 - 100);
    cfg = 8'hC1;
    run_to_acc(2000, t, m);
    chk(m == 50, "R8", "new length from boundary", m, 50);
    run_to_acc(2000, t, m);
    chk(m == 100, "R8", "second change at boundary", m, 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_slot_walk();
    t_gap();
    t_accum(8'h01, 42, 2, "R6");
    t_accum(8'h42, 100, 1, "R5");
    t_accum(8'h81, 84, 1, "R6");
    t_accum(8'hC1, 100, 1, "R6");
    t_accum(8'h00, 42, 2, "R7");
    t_accum(8'h03, 126, 1, "R5");
    t_cfg_change();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule